// File: doc/BRIEF.md
# Next-Fetch-Address Branch Predictor

This block turns a fetch PC plus predecode information into a predicted next fetch address for near branches. A direct-mapped branch target buffer (BTB), indexed by the fetch PC, supplies a stored target and a 2-bit direction counter. When the BTB has no entry for a conditional branch, a static rule takes over: backward branches are predicted taken and forward branches are predicted not taken. A 16-entry return stack predicts the target of returns.

The front end presents the fetch PC, a 3-bit branch-kind code, the sign of the displacement, the direct target computed by predecode and the sequential (fall-through) address. The prediction is combinational from these inputs. The return stack and the BTB change on the next rising clock edge. BTB entries are trained only from the retirement port. Far transfers are never predicted. For those, the block raises a no-prediction flag and passes the sequential address through.

Top module: `bp_next_pc`

## Requirements
- R1: After reset, every BTB lookup misses and the return stack is empty.
- R2: For kind codes 5 (far call), 6 (interrupt return) and 7 (software interrupt), `no_pred_o`=1, `pred_taken_o`=0 and `pred_pc_o` equals `seq_pc_i`, even if the BTB holds an entry for the PC.
- R3: A conditional branch (kind 1) that misses the BTB is predicted taken to `direct_tgt_i` when `disp_neg_i`=1. When `disp_neg_i`=0 it is predicted not taken to `seq_pc_i`.
- R4: A conditional branch that hits the BTB is predicted taken to the stored target when its counter is 2 or 3. It is predicted not taken to `seq_pc_i` when the counter is 0 or 1.
- R5: A retired taken branch that misses the BTB allocates the entry with the retired target and the counter at 2. A retired not-taken branch that misses allocates nothing.
- R6: A retired branch that hits the BTB steps its counter up when taken and down when not taken, saturating at 3 and 0. A taken branch also rewrites the stored target.
- R7: Fetch lookups never write the BTB. Only the retirement port changes it.
- R8: A call (kind 2) pushes `seq_pc_i`. A return (kind 3) pops the most recent entry and is predicted taken to it, in last-in first-out order.
- R9: A push onto a full 16-entry stack overwrites the oldest entry. Pops then return the 16 newest addresses, after which the stack is empty.
- R10: A return with an empty stack gives `no_pred_o`=1, `pred_taken_o`=0 and `pred_pc_o`=`seq_pc_i`.
- R11: An indirect branch (kind 4) that hits the BTB is predicted taken to the stored target. On a miss it gives `pred_pc_o`=`seq_pc_i` with `no_pred_o`=1.
- R12: A direct call is predicted taken. The target is the BTB target on a hit and `direct_tgt_i` on a miss.
- R13: A retirement update becomes visible to lookups from the cycle after its clock edge. A lookup in the same cycle sees the old contents.
- R14: With `fetch_valid_i`=0 the stack does not change and the outputs are `seq_pc_i`, not taken, no flag, no hit. Kind 0 gives the same outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| fetch_valid_i | input | 1 | Fetch lookup valid |
| fetch_pc_i | input | AW | PC of the fetched branch |
| br_kind_i | input | 3 | Kind code: 0 none, 1 cond, 2 call, 3 return, 4 indirect, 5 far call, 6 interrupt return, 7 software interrupt |
| disp_neg_i | input | 1 | Displacement is negative (backward) |
| seq_pc_i | input | AW | Fall-through address |
| direct_tgt_i | input | AW | Target decoded from the displacement |
| rt_valid_i | input | 1 | Retirement update valid |
| rt_pc_i | input | AW | PC of the retired branch |
| rt_target_i | input | AW | Resolved target |
| rt_taken_i | input | 1 | Resolved direction |
| pred_pc_o | output | AW | Predicted next fetch address |
| pred_taken_o | output | 1 | Predicted taken |
| no_pred_o | output | 1 | No prediction available |
| btb_hit_o | output | 1 | BTB hit for the fetch PC |

## Verification
All four outputs are combinational functions of the inputs and the stored state. The bench drives each lookup on the falling edge and samples it 1 ns later, in the same cycle. Stack pushes and pops, and retirement writes, take effect at the rising edge that follows. Their effect is checked on the lookup presented after that edge, one cycle after the stimulus. A lookup placed in the same cycle as a retirement write confirms that the write has not yet landed.

// File: rtl/bp_pkg.sv
package bp_pkg;
  typedef enum logic [2:0] {
    BK_NONE  = 3'd0,
    BK_COND  = 3'd1,
    BK_CALL  = 3'd2,
    BK_RET   = 3'd3,
    BK_IND   = 3'd4,
    BK_FCALL = 3'd5,
    BK_IRET  = 3'd6,
    BK_SWINT = 3'd7
  } br_kind_e;

  localparam int unsigned CTR_W = 2;
  localparam logic [CTR_W-1:0] CTR_WEAK_T = 2'd2;
endpackage

// File: rtl/bp_btb.sv
module bp_btb #(
  parameter int unsigned AW      = 32,
  parameter int unsigned ENTRIES = 64
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [AW-1:0]      lk_pc_i,
  output logic               lk_hit_o,
  output logic [AW-1:0]      lk_tgt_o,
  output logic [1:0]         lk_ctr_o,
  input  logic               up_valid_i,
  input  logic [AW-1:0]      up_pc_i,
  input  logic [AW-1:0]      up_tgt_i,
  input  logic               up_taken_i,
  output logic [ENTRIES-1:0] valid_o
);
  import bp_pkg::*;
  localparam int unsigned IW = $clog2(ENTRIES);
  localparam int unsigned TW = AW - IW - 2;

  logic [ENTRIES-1:0] valid_q;
  logic [TW-1:0]      tag_q [ENTRIES];
  logic [AW-1:0]      tgt_q [ENTRIES];
  logic [1:0]         ctr_q [ENTRIES];

  logic [IW-1:0] lk_idx, up_idx;
  logic [TW-1:0] lk_tag, up_tag;
  logic          up_hit;

  assign lk_idx = lk_pc_i[IW+1:2];
  assign lk_tag = lk_pc_i[AW-1:IW+2];
  assign up_idx = up_pc_i[IW+1:2];
  assign up_tag = up_pc_i[AW-1:IW+2];

  assign lk_hit_o = valid_q[lk_idx] && (tag_q[lk_idx] == lk_tag);
  assign lk_tgt_o = tgt_q[lk_idx];
  assign lk_ctr_o = ctr_q[lk_idx];
  assign up_hit   = valid_q[up_idx] && (tag_q[up_idx] == up_tag);
  assign valid_o  = valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
    end else if (up_valid_i && !up_hit && up_taken_i) begin
      valid_q[up_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < int'(ENTRIES); i++) ctr_q[i] <= '0;
    end else if (up_valid_i) begin
      if (up_hit) begin
        if (up_taken_i && ctr_q[up_idx] != 2'd3)       ctr_q[up_idx] <= ctr_q[up_idx] + 2'd1;
        else if (!up_taken_i && ctr_q[up_idx] != 2'd0) ctr_q[up_idx] <= ctr_q[up_idx] - 2'd1;
      end else if (up_taken_i) begin
        ctr_q[up_idx] <= CTR_WEAK_T;
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (up_valid_i && up_taken_i) begin
      tag_q[up_idx] <= up_tag;
      tgt_q[up_idx] <= up_tgt_i;
    end
  end
endmodule

// File: rtl/bp_ras.sv
module bp_ras #(
  parameter int unsigned AW    = 32,
  parameter int unsigned DEPTH = 16
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       push_i,
  input  logic                       pop_i,
  input  logic [AW-1:0]              push_addr_i,
  output logic [AW-1:0]              top_o,
  output logic                       empty_o,
  output logic [$clog2(DEPTH+1)-1:0] cnt_o
);
  localparam int unsigned PW = $clog2(DEPTH);
  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic [AW-1:0] mem_q [DEPTH];
  logic [PW-1:0] ptr_q;
  logic [CW-1:0] cnt_q;

  assign top_o   = mem_q[ptr_q - PW'(1)];
  assign empty_o = (cnt_q == '0);
  assign cnt_o   = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
      cnt_q <= '0;
    end else if (push_i) begin
      ptr_q <= ptr_q + PW'(1);
      if (cnt_q != FULL) cnt_q <= cnt_q + CW'(1);
    end else if (pop_i && !empty_o) begin
      ptr_q <= ptr_q - PW'(1);
      cnt_q <= cnt_q - CW'(1);
    end
  end

  // full stack wraps: the slot at ptr holds the oldest entry
  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[ptr_q] <= push_addr_i;
  end
endmodule

// File: rtl/bp_select.sv
module bp_select #(
  parameter int unsigned AW = 32
) (
  input  logic          valid_i,
  input  logic [2:0]    kind_i,
  input  logic          disp_neg_i,
  input  logic [AW-1:0] seq_pc_i,
  input  logic [AW-1:0] direct_tgt_i,
  input  logic          btb_hit_i,
  input  logic [AW-1:0] btb_tgt_i,
  input  logic [1:0]    btb_ctr_i,
  input  logic          ras_empty_i,
  input  logic [AW-1:0] ras_top_i,
  output logic [AW-1:0] pred_pc_o,
  output logic          taken_o,
  output logic          no_pred_o,
  output logic          push_o,
  output logic          pop_o
);
  import bp_pkg::*;
  br_kind_e kind;
  assign kind = br_kind_e'(kind_i);

  always_comb begin
    pred_pc_o = seq_pc_i;
    taken_o   = 1'b0;
    no_pred_o = 1'b0;
    push_o    = 1'b0;
    pop_o     = 1'b0;
    if (valid_i) begin
      unique case (kind)
        BK_COND: begin
          if (btb_hit_i) taken_o = btb_ctr_i[1];
          else           taken_o = disp_neg_i;
          if (taken_o) pred_pc_o = btb_hit_i ? btb_tgt_i : direct_tgt_i;
        end
        BK_CALL: begin
          taken_o   = 1'b1;
          pred_pc_o = btb_hit_i ? btb_tgt_i : direct_tgt_i;
          push_o    = 1'b1;
        end
        BK_RET: begin
          pop_o = 1'b1;
          if (ras_empty_i) begin
            no_pred_o = 1'b1;
          end else begin
            taken_o   = 1'b1;
            pred_pc_o = ras_top_i;
          end
        end
        BK_IND: begin
          if (btb_hit_i) begin
            taken_o   = 1'b1;
            pred_pc_o = btb_tgt_i;
          end else begin
            no_pred_o = 1'b1;
          end
        end
        BK_FCALL, BK_IRET, BK_SWINT: no_pred_o = 1'b1;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/bp_next_pc.sv
module bp_next_pc #(
  parameter int unsigned AW          = 32,
  parameter int unsigned BTB_ENTRIES = 64,
  parameter int unsigned RAS_DEPTH   = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          fetch_valid_i,
  input  logic [AW-1:0] fetch_pc_i,
  input  logic [2:0]    br_kind_i,
  input  logic          disp_neg_i,
  input  logic [AW-1:0] seq_pc_i,
  input  logic [AW-1:0] direct_tgt_i,
  input  logic          rt_valid_i,
  input  logic [AW-1:0] rt_pc_i,
  input  logic [AW-1:0] rt_target_i,
  input  logic          rt_taken_i,
  output logic [AW-1:0] pred_pc_o,
  output logic          pred_taken_o,
  output logic          no_pred_o,
  output logic          btb_hit_o
);
  localparam int unsigned CW = $clog2(RAS_DEPTH + 1);

  logic                   hit;
  logic [AW-1:0]          btb_tgt, ras_top;
  logic [1:0]             btb_ctr;
  logic [BTB_ENTRIES-1:0] btb_valid;
  logic                   push, pop, ras_empty;
  logic [CW-1:0]          ras_cnt;

  bp_btb #(.AW(AW), .ENTRIES(BTB_ENTRIES)) u_btb (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .lk_pc_i(fetch_pc_i), .lk_hit_o(hit), .lk_tgt_o(btb_tgt), .lk_ctr_o(btb_ctr),
    .up_valid_i(rt_valid_i), .up_pc_i(rt_pc_i), .up_tgt_i(rt_target_i),
    .up_taken_i(rt_taken_i), .valid_o(btb_valid)
  );

  bp_ras #(.AW(AW), .DEPTH(RAS_DEPTH)) u_ras (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .push_i(push), .pop_i(pop), .push_addr_i(seq_pc_i),
    .top_o(ras_top), .empty_o(ras_empty), .cnt_o(ras_cnt)
  );

  bp_select #(.AW(AW)) u_sel (
    .valid_i(fetch_valid_i), .kind_i(br_kind_i), .disp_neg_i(disp_neg_i),
    .seq_pc_i(seq_pc_i), .direct_tgt_i(direct_tgt_i),
    .btb_hit_i(hit), .btb_tgt_i(btb_tgt), .btb_ctr_i(btb_ctr),
    .ras_empty_i(ras_empty), .ras_top_i(ras_top),
    .pred_pc_o(pred_pc_o), .taken_o(pred_taken_o), .no_pred_o(no_pred_o),
    .push_o(push), .pop_o(pop)
  );

  assign btb_hit_o = fetch_valid_i && hit;
endmodule

// File: rtl/bp_next_pc_chk.sv
module bp_next_pc_chk #(
  parameter int unsigned AW          = 32,
  parameter int unsigned BTB_ENTRIES = 64,
  parameter int unsigned RAS_DEPTH   = 16
) (
  input logic                           clk_i,
  input logic                           rst_ni,
  input logic                           fetch_valid_i,
  input logic [2:0]                     br_kind_i,
  input logic                           disp_neg_i,
  input logic [AW-1:0]                  seq_pc_i,
  input logic [AW-1:0]                  direct_tgt_i,
  input logic                           rt_valid_i,
  input logic [AW-1:0]                  pred_pc_o,
  input logic                           pred_taken_o,
  input logic                           no_pred_o,
  input logic                           btb_hit_o,
  input logic [$clog2(RAS_DEPTH+1)-1:0] ras_cnt,
  input logic [BTB_ENTRIES-1:0]         btb_valid
);
  localparam int unsigned CW = $clog2(RAS_DEPTH + 1);
  localparam logic [CW-1:0] FULL = CW'(RAS_DEPTH);

  a_r2_far_no_pred: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fetch_valid_i && br_kind_i >= 3'd5) |-> (no_pred_o && !pred_taken_o && pred_pc_o == seq_pc_i));

  a_r3_static_backward: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fetch_valid_i && br_kind_i == 3'd1 && !btb_hit_o && disp_neg_i)
      |-> (pred_taken_o && pred_pc_o == direct_tgt_i));

  a_r7_btb_write_only_retire: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rt_valid_i |=> $stable(btb_valid));

  a_r8_call_pushes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fetch_valid_i && br_kind_i == 3'd2 && ras_cnt != FULL) |=> ras_cnt == $past(ras_cnt) + CW'(1));

  a_r9_full_stays_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fetch_valid_i && br_kind_i == 3'd2 && ras_cnt == FULL) |=> ras_cnt == FULL);

  a_r10_empty_ret: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fetch_valid_i && br_kind_i == 3'd3 && ras_cnt == '0) |-> (no_pred_o && pred_pc_o == seq_pc_i));

  a_r14_idle_holds_stack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fetch_valid_i |=> $stable(ras_cnt));

  a_r14_idle_outputs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fetch_valid_i |-> (!no_pred_o && !pred_taken_o && !btb_hit_o && pred_pc_o == seq_pc_i));
endmodule

bind bp_next_pc bp_next_pc_chk #(.AW(AW), .BTB_ENTRIES(BTB_ENTRIES), .RAS_DEPTH(RAS_DEPTH)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .fetch_valid_i(fetch_valid_i), .br_kind_i(br_kind_i),
  .disp_neg_i(disp_neg_i), .seq_pc_i(seq_pc_i), .direct_tgt_i(direct_tgt_i),
  .rt_valid_i(rt_valid_i), .pred_pc_o(pred_pc_o), .pred_taken_o(pred_taken_o),
  .no_pred_o(no_pred_o), .btb_hit_o(btb_hit_o), .ras_cnt(ras_cnt), .btb_valid(btb_valid)
);

// File: tb/bp_next_pc_tb.sv
module bp_next_pc_tb;
  localparam int unsigned AW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          fv = 1'b0;
  logic [AW-1:0] fpc = '0, seq = '0, dtgt = '0;
  logic [2:0]    kind = '0;
  logic          neg = 1'b0;
  logic          rv = 1'b0, rtk = 1'b0;
  logic [AW-1:0] rpc = '0, rtgt = '0;
  logic [AW-1:0] ppc;
  logic          ptk, npred, hit;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  bp_next_pc u_dut (
    .clk_i(clk), .rst_ni(rst_n), .fetch_valid_i(fv), .fetch_pc_i(fpc), .br_kind_i(kind),
    .disp_neg_i(neg), .seq_pc_i(seq), .direct_tgt_i(dtgt),
    .rt_valid_i(rv), .rt_pc_i(rpc), .rt_target_i(rtgt), .rt_taken_i(rtk),
    .pred_pc_o(ppc), .pred_taken_o(ptk), .no_pred_o(npred), .btb_hit_o(hit)
  );

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic fetch(input logic [2:0] k, input logic [AW-1:0] pc, input logic [AW-1:0] s,
                       input logic [AW-1:0] t, input logic n);
    fv = 1'b1; kind = k; fpc = pc; seq = s; dtgt = t; neg = n;
    #1;
  endtask

  task automatic idle();
    fv = 1'b0; kind = 3'd0;
    #1;
  endtask

  task automatic retire(input logic [AW-1:0] pc, input logic [AW-1:0] t, input logic tk);
    idle();
    rv = 1'b1; rpc = pc; rtgt = t; rtk = tk;
    step();
    rv = 1'b0;
  endtask

  // result packed as {hit, no_pred, taken, pc}
  task automatic chk(input string req, input logic [AW+2:0] exp);
    logic [AW+2:0] act;
    act = {hit, npred, ptk, ppc};
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: act hit/np/tk/pc=%b/%b/%b/%h exp=%b/%b/%b/%h", req,
               act[AW+2], act[AW+1], act[AW], act[AW-1:0], exp[AW+2], exp[AW+1], exp[AW], exp[AW-1:0]);
    end
  endtask

  initial begin
    #(8 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: act=timeout exp=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 / R10: empty stack, empty BTB
    fetch(3'd3, 32'h100, 32'h104, 32'h0, 1'b0);
    chk("R1_R10 empty ret", {1'b0, 1'b1, 1'b0, 32'h104});
    fetch(3'd1, 32'h100, 32'h104, 32'h80, 1'b0);
    chk("R1 btb empty", {1'b0, 1'b0, 1'b0, 32'h104});

    // R14 idle outputs
    idle(); seq = 32'h55; #1;
    chk("R14 idle", {1'b0, 1'b0, 1'b0, 32'h55});
    fetch(3'd0, 32'h100, 32'h104, 32'h80, 1'b1);
    chk("R14 kind none", {1'b0, 1'b0, 1'b0, 32'h104});

    // R3 static sweep
    for (int i = 0; i < 8; i++) begin
      logic [AW-1:0] pc;
      pc = 32'h1000 + 32'(i) * 32'h44;
      fetch(3'd1, pc, pc + 4, pc - 32'h20 + 32'(i[0]) * 32'h40, i[0]);
      chk("R3 static", {1'b0, 1'b0, i[0], i[0] ? (pc + 32'h20) : (pc + 4)});
      step();
    end

    // R5 allocation, R13 timing
    idle();
    rv = 1'b1; rpc = 32'h200; rtgt = 32'h300; rtk = 1'b1;
    fetch(3'd1, 32'h200, 32'h204, 32'h280, 1'b0);
    chk("R13 same-cycle old", {1'b0, 1'b0, 1'b0, 32'h204});
    step();
    rv = 1'b0;
    fetch(3'd1, 32'h200, 32'h204, 32'h280, 1'b0);
    chk("R5_R13 alloc weak taken", {1'b1, 1'b0, 1'b1, 32'h300});
    retire(32'h240, 32'h900, 1'b0);
    fetch(3'd1, 32'h240, 32'h244, 32'h900, 1'b0);
    chk("R5 not-taken no alloc", {1'b0, 1'b0, 1'b0, 32'h244});

    // R2 far kinds sweep, with a BTB entry present at the PC
    for (int k = 5; k < 8; k++) begin
      fetch(3'(k), 32'h200, 32'h204, 32'h280, 1'b1);
      chk("R2 far", {1'b1, 1'b1, 1'b0, 32'h204});
      step();
    end

    // R6 / R4 counter behaviour on 0x200 (now 2)
    retire(32'h200, 32'h300, 1'b1);
    retire(32'h200, 32'h300, 1'b1);
    retire(32'h200, 32'h300, 1'b0);
    fetch(3'd1, 32'h200, 32'h204, 32'h0, 1'b0);
    chk("R4_R6 sat high then dec", {1'b1, 1'b0, 1'b1, 32'h300});
    retire(32'h200, 32'h300, 1'b0);
    fetch(3'd1, 32'h200, 32'h204, 32'h0, 1'b1);
    chk("R4 weak not taken", {1'b1, 1'b0, 1'b0, 32'h204});
    for (int i = 0; i < 3; i++) retire(32'h200, 32'h300, 1'b0);
    retire(32'h200, 32'h340, 1'b1);
    fetch(3'd1, 32'h200, 32'h204, 32'h0, 1'b0);
    chk("R6 sat low", {1'b1, 1'b0, 1'b0, 32'h204});
    retire(32'h200, 32'h380, 1'b1);
    fetch(3'd1, 32'h200, 32'h204, 32'h0, 1'b0);
    chk("R6 target rewrite", {1'b1, 1'b0, 1'b1, 32'h380});

    // R7 fetches do not write the BTB
    for (int i = 0; i < 4; i++) begin
      fetch(3'd1 + 3'(i % 2), 32'h400, 32'h404, 32'h500, 1'b1);
      step();
    end
    fetch(3'd4, 32'h400, 32'h404, 32'h500, 1'b0);
    chk("R7_R11 no fetch write", {1'b0, 1'b1, 1'b0, 32'h404});
    idle();
    fetch(3'd3, 32'h404, 32'h408, 32'h0, 1'b0);
    step();   // two calls were pushed above; drain them
    fetch(3'd3, 32'h404, 32'h408, 32'h0, 1'b0);
    step();
    fetch(3'd3, 32'h404, 32'h408, 32'h0, 1'b0);
    chk("R10 drained", {1'b0, 1'b1, 1'b0, 32'h408});

    // R11 indirect hit
    retire(32'h6000, 32'h7000, 1'b1);
    fetch(3'd4, 32'h6000, 32'h6004, 32'h0, 1'b0);
    chk("R11 indirect hit", {1'b1, 1'b0, 1'b1, 32'h7000});

    // R8 LIFO
    for (int i = 0; i < 3; i++) begin
      fetch(3'd2, 32'h1000 * (i + 1), 32'h1000 * (i + 1) + 4, 32'h2, 1'b0);
      step();
    end
    for (int i = 2; i >= 0; i--) begin
      fetch(3'd3, 32'h50, 32'h54, 32'h0, 1'b0);
      chk("R8 lifo pop", {1'b0, 1'b0, 1'b1, 32'h1000 * (i + 1) + 4});
      step();
    end

    // R12 direct call miss then hit
    fetch(3'd2, 32'h8004, 32'h8008, 32'h9000, 1'b0);
    chk("R12 call miss", {1'b0, 1'b0, 1'b1, 32'h9000});
    step();
    retire(32'h8004, 32'hA000, 1'b1);
    fetch(3'd2, 32'h8004, 32'h8008, 32'h9000, 1'b0);
    chk("R12 call hit", {1'b1, 1'b0, 1'b1, 32'hA000});
    step();
    for (int i = 0; i < 2; i++) begin
      fetch(3'd3, 32'h60, 32'h64, 32'h0, 1'b0);
      chk("R8_R12 call pushed", {1'b0, 1'b0, 1'b1, 32'h8008});
      step();
    end

    // R9 wrap
    for (int i = 0; i < 17; i++) begin
      fetch(3'd2, 32'h4000, 32'h5000 + 32'(i) * 4, 32'h4100, 1'b0);
      step();
    end
    for (int j = 0; j < 16; j++) begin
      fetch(3'd3, 32'h70, 32'h74, 32'h0, 1'b0);
      chk("R9 wrap pop", {1'b0, 1'b0, 1'b1, 32'h5000 + 32'(16 - j) * 4});
      step();
    end
    fetch(3'd3, 32'h70, 32'h74, 32'h0, 1'b0);
    chk("R9_R10 empty after wrap", {1'b0, 1'b1, 1'b0, 32'h74});

    // R14 invalid call does not push
    fv = 1'b0; kind = 3'd2; seq = 32'hBEEC; #1;
    step();
    fetch(3'd3, 32'h70, 32'h74, 32'h0, 1'b0);
    chk("R14 no push when idle", {1'b0, 1'b1, 1'b0, 32'h74});
    idle();

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule